// File: doc/BRIEF.md
# Palette DAC Programming Interface

A 256-entry colour lookup table with one 8-bit red, one 8-bit green and one 8-bit blue byte per entry. A CPU loads the table through two write registers. The index register selects the entry. The colour-map data register accepts component bytes. Each data byte goes to the component chosen by a phase counter that steps red, green, blue. After blue, the counter returns to red and the index moves on by one. The CPU can send a single byte or a 32-bit word. A word is treated as four component writes in a row, taking the most significant byte first.

A separate scan-out port takes an 8-bit pixel value and returns the 24-bit colour stored for it, one clock later. A one-cycle change pulse follows every data-register write, so a display consumer can schedule a full repaint.

Top module: `palette_dac`

## Requirements
- R1: A write with `bus_addr_i` = 0x0 targets the index register and a write with `bus_addr_i` = 0x4 targets the colour-map data register. A write to any other offset leaves the table, the index and the phase unchanged, and produces no change pulse.
- R2: An index-register write loads `bus_wdata_i[7:0]` as the current index and sets the phase to red, even when the previous entry was partly written.
- R3: A data byte is stored into red in phase 0, green in phase 1 and blue in phase 2 of the current entry. The phase advances by one after red and after green, and the index stays the same.
- R4: After a blue byte is stored, the index increments modulo 256 (255 wraps to 0) and the phase returns to red.
- R5: A word write (`bus_size_i` = 1) acts as four component writes, in the order bits 31:24, 23:16, 15:8 and 7:0. Each of the four bytes steps the phase and index as in R3 and R4, so one word can span two entries.
- R6: A byte write (`bus_size_i` = 0) stores only `bus_wdata_i[7:0]`, as a single component write.
- R7: After reset, all 768 table bytes are zero, the index is 0 and the phase is red.
- R8: `bus_rdata_o` reads as zero at every offset, including 0x0 and 0x4.
- R9: `rgb_o` is {red[p], green[p], blue[p]}, with red in bits 23:16, for the `pix_i` value p present at the previous rising clock edge. A lookup in the same cycle as a write to the same entry returns the contents from before that write.
- R10: `pal_changed_o` is high for exactly the one cycle after each data-register write, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_we_i | input | 1 | Bus write strobe |
| bus_addr_i | input | 5 | Register byte offset |
| bus_size_i | input | 1 | 0 = byte access, 1 = 32-bit word access |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, always zero |
| pix_i | input | 8 | Pixel value for scan-out lookup |
| rgb_o | output | 24 | Registered colour {red, green, blue} |
| pal_changed_o | output | 1 | One-cycle pulse after a data write |

## Verification
The scan-out lookup and a CPU component write can land on the same table entry in the same cycle. The bench forces this on purpose: it drives a data byte write and a `pix_i` value naming the entry being written in the same cycle. It expects `rgb_o` to show the old colour on the next cycle and the new colour one lookup later. Random streams mix byte writes, word writes, index reloads and writes to unused offsets, each followed by a lookup. Those lookups also often hit an entry that was just written, and the results are judged against a bench model of the table and the phase counter.

// File: rtl/palette_dac_pkg.sv
package palette_dac_pkg;
  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } phase_e;
  localparam int unsigned NUM_COMP = 3;
endpackage

// File: rtl/palette_dac_seq.sv
module palette_dac_seq
  import palette_dac_pkg::*;
#(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned COMP_W = 8,
  parameter int unsigned LANES  = 4,
  localparam int unsigned BUS_W = LANES * COMP_W
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         idx_we_i,
  input  logic                         map_we_i,
  input  logic                         word_i,
  input  logic [BUS_W-1:0]             wdata_i,
  output logic [LANES-1:0]             step_vld_o,
  output logic [LANES-1:0][IDX_W-1:0]  step_idx_o,
  output logic [LANES-1:0][1:0]        step_ph_o,
  output logic [LANES-1:0][COMP_W-1:0] step_dat_o,
  output logic [1:0]                   ph_o,
  output logic [IDX_W-1:0]             idx_o
);
  phase_e           ph_q;
  logic [IDX_W-1:0] idx_q;

  phase_e           ph_c [LANES+1];
  logic [IDX_W-1:0] ix_c [LANES+1];

  assign ph_c[0] = ph_q;
  assign ix_c[0] = idx_q;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    // each lane is one component write; lane 0 carries the byte-access data
    assign ph_c[k+1] = (ph_c[k] == PH_BLU) ? PH_RED : phase_e'(ph_c[k] + 2'd1);
    assign ix_c[k+1] = ix_c[k] + IDX_W'(ph_c[k] == PH_BLU);
    assign step_vld_o[k] = map_we_i && (word_i || (k == 0));
    assign step_idx_o[k] = ix_c[k];
    assign step_ph_o[k]  = ph_c[k];
    assign step_dat_o[k] = word_i ? wdata_i[BUS_W-1-k*COMP_W -: COMP_W]
                                  : wdata_i[COMP_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_RED;
      idx_q <= '0;
    end else if (idx_we_i) begin
      ph_q  <= PH_RED;
      idx_q <= wdata_i[IDX_W-1:0];
    end else if (map_we_i) begin
      ph_q  <= word_i ? ph_c[LANES] : ph_c[1];
      idx_q <= word_i ? ix_c[LANES] : ix_c[1];
    end
  end

  assign ph_o  = ph_q;
  assign idx_o = idx_q;
endmodule

// File: rtl/palette_dac_ram.sv
module palette_dac_ram
  import palette_dac_pkg::*;
#(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned COMP_W = 8,
  parameter int unsigned LANES  = 4,
  localparam int unsigned ENTRIES = 1 << IDX_W
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [LANES-1:0]             step_vld_i,
  input  logic [LANES-1:0][IDX_W-1:0]  step_idx_i,
  input  logic [LANES-1:0][1:0]        step_ph_i,
  input  logic [LANES-1:0][COMP_W-1:0] step_dat_i,
  input  logic [IDX_W-1:0]             pix_i,
  output logic [NUM_COMP*COMP_W-1:0]   rgb_o
);
  for (genvar c = 0; c < NUM_COMP; c++) begin : g_comp
    logic [COMP_W-1:0] tbl [ENTRIES];
    logic [COMP_W-1:0] look_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < ENTRIES; i++) tbl[i] <= '0;
      end else begin
        for (int k = 0; k < LANES; k++) begin
          if (step_vld_i[k] && (step_ph_i[k] == 2'(c))) tbl[step_idx_i[k]] <= step_dat_i[k];
        end
      end
    end

    // read-before-write: lookup sees contents prior to this edge's writes
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) look_q <= '0;
      else         look_q <= tbl[pix_i];
    end

    assign rgb_o[(NUM_COMP-1-c)*COMP_W +: COMP_W] = look_q;
  end
endmodule

// File: rtl/palette_dac.sv
module palette_dac
  import palette_dac_pkg::*;
#(
  parameter int unsigned IDX_W   = 8,
  parameter int unsigned COMP_W  = 8,
  parameter int unsigned BUS_W   = 32,
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned IDX_OFS = 0,
  parameter int unsigned MAP_OFS = 4,
  localparam int unsigned LANES  = BUS_W / COMP_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       bus_we_i,
  input  logic [ADDR_W-1:0]          bus_addr_i,
  input  logic                       bus_size_i,
  input  logic [BUS_W-1:0]           bus_wdata_i,
  output logic [BUS_W-1:0]           bus_rdata_o,
  input  logic [IDX_W-1:0]           pix_i,
  output logic [NUM_COMP*COMP_W-1:0] rgb_o,
  output logic                       pal_changed_o
);
  logic idx_we, map_we;
  logic [LANES-1:0]             step_vld;
  logic [LANES-1:0][IDX_W-1:0]  step_idx;
  logic [LANES-1:0][1:0]        step_ph;
  logic [LANES-1:0][COMP_W-1:0] step_dat;
  logic [1:0]                   seq_ph;
  logic [IDX_W-1:0]             seq_idx;
  logic                         chg_q;

  assign idx_we = bus_we_i && (bus_addr_i == ADDR_W'(IDX_OFS));
  assign map_we = bus_we_i && (bus_addr_i == ADDR_W'(MAP_OFS)) && !idx_we;

  palette_dac_seq #(.IDX_W(IDX_W), .COMP_W(COMP_W), .LANES(LANES)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .idx_we_i   (idx_we),
    .map_we_i   (map_we),
    .word_i     (bus_size_i),
    .wdata_i    (bus_wdata_i),
    .step_vld_o (step_vld),
    .step_idx_o (step_idx),
    .step_ph_o  (step_ph),
    .step_dat_o (step_dat),
    .ph_o       (seq_ph),
    .idx_o      (seq_idx)
  );

  palette_dac_ram #(.IDX_W(IDX_W), .COMP_W(COMP_W), .LANES(LANES)) u_ram (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_vld_i (step_vld),
    .step_idx_i (step_idx),
    .step_ph_i  (step_ph),
    .step_dat_i (step_dat),
    .pix_i      (pix_i),
    .rgb_o      (rgb_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chg_q <= 1'b0;
    else         chg_q <= map_we;
  end

  assign pal_changed_o = chg_q;
  assign bus_rdata_o   = '0;
endmodule

// File: rtl/palette_dac_chk.sv
module palette_dac_chk #(
  parameter int unsigned IDX_W   = 8,
  parameter int unsigned BUS_W   = 32,
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned IDX_OFS = 0,
  parameter int unsigned MAP_OFS = 4,
  parameter int unsigned LANES   = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              bus_size_i,
  input logic [BUS_W-1:0]  bus_wdata_i,
  input logic              pal_changed_o,
  input logic [1:0]        seq_ph,
  input logic [IDX_W-1:0]  seq_idx
);
  logic wr_idx, wr_map, wr_other;
  assign wr_idx   = bus_we_i && (bus_addr_i == ADDR_W'(IDX_OFS));
  assign wr_map   = bus_we_i && (bus_addr_i == ADDR_W'(MAP_OFS));
  assign wr_other = bus_we_i && !wr_idx && !wr_map;

  assert_ignored_write_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_other |=> $stable(seq_ph) && $stable(seq_idx));

  assert_index_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_idx |=> (seq_ph == 2'd0) && (seq_idx == $past(bus_wdata_i[IDX_W-1:0])));

  assert_phase_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_map && !bus_size_i && seq_ph != 2'd2)
      |=> (seq_ph == $past(seq_ph) + 2'd1) && $stable(seq_idx));

  assert_index_advance_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_map && !bus_size_i && seq_ph == 2'd2)
      |=> (seq_ph == 2'd0) && (seq_idx == $past(seq_idx) + IDX_W'(1)));

  assert_phase_legal_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_ph != 2'd3);

  if (LANES == 4) begin : g_word
    assert_word_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_map && bus_size_i)
        |=> (seq_ph == (($past(seq_ph) == 2'd2) ? 2'd0 : $past(seq_ph) + 2'd1))
         && (seq_idx == $past(seq_idx) + (($past(seq_ph) == 2'd2) ? IDX_W'(2) : IDX_W'(1))));
  end

  assert_change_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_map |=> pal_changed_o);

  assert_change_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_map |=> !pal_changed_o);
endmodule

bind palette_dac palette_dac_chk #(
  .IDX_W(IDX_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W),
  .IDX_OFS(IDX_OFS), .MAP_OFS(MAP_OFS), .LANES(LANES)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .bus_we_i      (bus_we_i),
  .bus_addr_i    (bus_addr_i),
  .bus_size_i    (bus_size_i),
  .bus_wdata_i   (bus_wdata_i),
  .pal_changed_o (pal_changed_o),
  .seq_ph        (seq_ph),
  .seq_idx       (seq_idx)
);

// File: tb/palette_dac_bench.sv
module palette_dac_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic        size = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  pix = '0;
  logic [23:0] rgb;
  logic        chg;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] rm [256];
  logic [7:0] gm [256];
  logic [7:0] bm [256];
  logic [7:0] idx_m = '0;
  int         ph_m = 0;

  always #2 clk = ~clk;

  palette_dac u_palette_dac (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_size_i(size), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .pix_i(pix), .rgb_o(rgb), .pal_changed_o(chg)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [23:0] mdl_rgb(input logic [7:0] p);
    return {rm[p], gm[p], bm[p]};
  endfunction

  function automatic void mdl_byte(input logic [7:0] b);
    case (ph_m)
      0: begin rm[idx_m] = b; ph_m = 1; end
      1: begin gm[idx_m] = b; ph_m = 2; end
      default: begin bm[idx_m] = b; idx_m = idx_m + 8'd1; ph_m = 0; end
    endcase
  endfunction

  function automatic void mdl_write(input logic [4:0] a, input logic sz, input logic [31:0] d);
    if (a == 5'h0) begin
      idx_m = d[7:0];
      ph_m  = 0;
    end else if (a == 5'h4) begin
      if (sz) begin
        mdl_byte(d[31:24]); mdl_byte(d[23:16]); mdl_byte(d[15:8]); mdl_byte(d[7:0]);
      end else begin
        mdl_byte(d[7:0]);
      end
    end
  endfunction

  task automatic wr(input logic [4:0] a, input logic sz, input logic [31:0] d);
    we = 1'b1; addr = a; size = sz; wdata = d;
    step();
    mdl_write(a, sz, d);
    chk(chg == (a == 5'h4), "R10 change pulse", 32'(chg), 32'(a == 5'h4));
    we = 1'b0;
  endtask

  task automatic look(input logic [7:0] p, input string req);
    pix = p;
    step();
    chk(rgb == mdl_rgb(p), req, 32'(rgb), 32'(mdl_rgb(p)));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [23:0] old;
    int unsigned seed;
    for (int i = 0; i < 256; i++) begin rm[i] = '0; gm[i] = '0; bm[i] = '0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();
    // R7 reset state
    look(8'h00, "R7 reset entry 0");
    look(8'hFF, "R7 reset entry 255");
    look(8'h80, "R7 reset entry 128");
    chk(chg == 1'b0, "R10 idle after reset", 32'(chg), 32'h0);
    addr = 5'h0; #1;
    chk(rdata == 32'h0, "R8 read index offset", rdata, 32'h0);
    addr = 5'h4; #1;
    chk(rdata == 32'h0, "R8 read map offset", rdata, 32'h0);

    // R6 byte uses low byte, R7 phase red at index 0
    wr(5'h4, 1'b0, 32'hAABBCC11);
    look(8'h00, "R6 low byte into red of entry 0");
    wr(5'h4, 1'b0, 32'h00000022);
    wr(5'h4, 1'b0, 32'h00000033);
    look(8'h00, "R3 full entry 0");
    wr(5'h4, 1'b0, 32'h00000044);
    look(8'h01, "R4 advanced to entry 1");
    chk(chg == 1'b0, "R10 single cycle pulse", 32'(chg), 32'h0);

    // R2 index reload mid-entry
    wr(5'h0, 1'b0, 32'h00000005);
    wr(5'h4, 1'b0, 32'h00000055);
    wr(5'h0, 1'b0, 32'h00000005);
    wr(5'h4, 1'b0, 32'h00000066);
    look(8'h05, "R2 reload resets phase to red");

    // R4/R5 word spanning wrap from 255 to 0
    wr(5'h0, 1'b0, 32'h000000FF);
    wr(5'h4, 1'b1, 32'h01020304);
    look(8'hFF, "R5 word order entry 255");
    look(8'h00, "R4 wrap into entry 0");

    // R1 write to unused offset has no effect
    wr(5'h10, 1'b1, 32'hDEADBEEF);
    look(8'h00, "R1 unused offset leaves table");
    wr(5'h4, 1'b0, 32'h00000077);
    look(8'h00, "R1 phase kept after unused write");
    addr = 5'h4; #1;
    chk(rdata == 32'h0, "R8 read after writes", rdata, 32'h0);

    // R9 lookup collides with write to the same entry
    wr(5'h0, 1'b0, 32'h00000040);
    old = mdl_rgb(8'h40);
    we = 1'b1; addr = 5'h4; size = 1'b0; wdata = 32'h00000099; pix = 8'h40;
    step();
    chk(rgb == old, "R9 same-cycle lookup returns old", 32'(rgb), 32'(old));
    mdl_write(5'h4, 1'b0, 32'h00000099);
    we = 1'b0;
    look(8'h40, "R9 next lookup returns new");

    // random mix
    seed = $urandom(32'd24681);
    for (int n = 0; n < 600; n++) begin
      int unsigned r;
      logic [4:0] a;
      r = $urandom % 10;
      if (r < 2) a = 5'h0;
      else if (r < 9) a = 5'h4;
      else begin
        a = 5'($urandom % 32);
        if (a == 5'h0 || a == 5'h4) a = 5'h8;
      end
      wr(a, 1'($urandom % 2), $urandom);
      if (n % 3 == 0) look(idx_m, "R3 random lookup current entry");
      else            look(8'($urandom % 256), "R5 random lookup");
    end
    for (int i = 0; i < 256; i++) look(8'(i), "R9 final sweep");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule